// File: doc/BRIEF.md
# Quad SPI to APB Bridge

This block is a serial target that lets an external host reach an internal APB management bus through a memory-mapped quad SPI link. The host sends a one-line opcode, then a 32-bit address over four lines. For a read, it clocks a fixed number of idle cycles and then collects 32-bit words. For a write, it streams 32-bit words straight after the address. Each word becomes one APB transfer at an address that rises by four for every word.

The host has no way to wait. Every APB read therefore has to finish within a fixed cycle budget. The first word must complete within the idle cycles. Each later word must complete within the eight clocks of the word before it, which is why the block requests adjacent words ahead of time. When a result misses its window, a filler word goes out in its place and a sticky flag records the miss.

The serial clock and the APB clock are independent. Requests cross from the serial domain to the APB domain, and results cross back, through a toggle request/acknowledge pair.

Top module: `qspi_apb_bridge`

## Requirements
- R1: After `presetn` is low, `psel`, `penable`, `io_oe`, `timeout_o` and `slverr_o` are all 0.
- R2: The opcode is 8 bits, sampled on `io_i[0]` at rising `sck` edges, MSB first. 0x6B selects a read and 0x32 selects a write. Any other opcode makes the block ignore the rest of the frame: it starts no APB transfer and `io_oe` stays 0.
- R3: The address follows the opcode as 8 nibbles on `io_i[3:0]`, most significant nibble first. A read then takes DUMMY_CYCLES idle clocks. Read data leaves on `io_o[3:0]`, most significant nibble first. Each nibble changes after a rising edge, and the host samples it at the next rising edge.
- R4: Every APB transfer has one setup cycle with `psel`=1 and `penable`=0, then an access phase with both high. The access phase holds `paddr`, `pwrite` and `pwdata` until `pready`=1, and `penable` drops after completion.
- R5: Read word k of a frame at address A comes from APB address A+4k. At most MAX_BURST_WORDS (8) APB reads are made per frame. Words beyond that limit return 0xDEADBEEF without an APB access and without setting `timeout_o`.
- R6: A read result that has not returned by the end of its window yields 0xDEADBEEF for that word. The window ends at the last idle clock for word 0, and at the last nibble of the previous word for later words. A miss also sets `timeout_o`, which stays 1 until reset.
- R7: A read completed with `pslverr`=1 returns 0xDEADBEEF to the host and sets `slverr_o`, which stays 1 until reset.
- R8: A write frame produces one APB write per complete 32-bit word, to A+4k, with the data assembled most significant nibble first. A partial word left when `cs_n` rises produces no transfer.
- R9: `io_oe` is 4'hF only during the read data phase and 4'h0 otherwise. Raising `cs_n` tri-states the lines at once and restarts opcode decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low frame select from host |
| io_i | input | 4 | Serial data lines, input side |
| io_o | output | 4 | Serial data lines, output side |
| io_oe | output | 4 | Output enable per data line |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction, 1 = write |
| paddr | output | 32 | APB address |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB completion |
| pslverr | input | 1 | APB error response |
| timeout_o | output | 1 | Sticky missed-window flag (APB domain) |
| slverr_o | output | 1 | Sticky APB error flag |

## Verification
Reads are driven with a fast slave, with a slave that inserts a few wait states, and with a slave that stalls far past the idle window. Comparing those runs separates correct word timing from filler substitution and from the sticky flag. A ten-word burst exposes the per-frame read limit and the address stepping of the prefetch. Single-word and two-words-plus-a-fragment writes show whether fragments are dropped. An unknown opcode and an error-returning address check that the frame is ignored and that the error path is taken.

// File: rtl/qsab_pkg.sv
`timescale 1ns/1ps
package qsab_pkg;
    typedef enum logic [2:0] {
        PH_CMD, PH_ADDR, PH_DUMMY, PH_RDATA, PH_WDATA, PH_SKIP
    } link_phase_e;

    typedef enum logic [1:0] {
        AP_IDLE, AP_SETUP, AP_ACCESS
    } apb_phase_e;

    localparam logic [7:0]  OP_QREAD  = 8'h6B;
    localparam logic [7:0]  OP_QWRITE = 8'h32;
    localparam logic [31:0] FILL_WORD = 32'hDEADBEEF;
endpackage

// File: rtl/qsab_link.sv
`timescale 1ns/1ps
module qsab_link
    import qsab_pkg::*;
#(
    parameter int DUMMY_CYCLES    = 8,
    parameter int MAX_BURST_WORDS = 8
) (
    input  logic        sck,
    input  logic        cs_n,
    input  logic        rst_n,
    input  logic [3:0]  io_i,
    output logic [3:0]  io_o,
    output logic [3:0]  io_oe,
    output logic        req_tgl_o,
    output logic        req_write_o,
    output logic [31:0] req_addr_o,
    output logic [31:0] req_wdata_o,
    input  logic        ack_tgl_i,
    input  logic [31:0] rsp_data_i,
    output logic        timeout_o
);
    localparam int CNT_MAX = (DUMMY_CYCLES > 8) ? DUMMY_CYCLES : 8;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam int BURST_W = $clog2(MAX_BURST_WORDS + 1);
    localparam logic [CNT_W-1:0]   LAST_NIB   = CNT_W'(7);
    localparam logic [CNT_W-1:0]   LAST_DUMMY = CNT_W'(DUMMY_CYCLES - 1);
    localparam logic [BURST_W-1:0] BURST_LIM  = BURST_W'(MAX_BURST_WORDS);

    typedef struct packed {
        link_phase_e        phase;
        logic [CNT_W-1:0]   cnt;
        logic               is_read;
        logic [7:0]         cmd;
        logic [31:0]        addr;
        logic [31:0]        sh;
        logic [31:0]        next_addr;
        logic [BURST_W-1:0] loaded;
        logic [BURST_W-1:0] issued;
        logic               have_req;
    } frame_t;

    typedef struct packed {
        logic        req_tgl;
        logic        req_write;
        logic [31:0] req_addr;
        logic [31:0] req_wdata;
        logic        ack_s1;
        logic        ack_s2;
        logic        timeout;
    } hs_t;

    frame_t f_d, f_q;
    hs_t    h_d, h_q;

    logic        pending;
    logic        check_edge;
    logic        iss;
    logic        iss_wr;
    logic [31:0] iss_addr;
    logic [31:0] iss_data;
    logic [7:0]  cmd_full;
    logic [31:0] addr_full;
    logic [31:0] win_full;
    logic        frame_rst;

    assign frame_rst = cs_n | ~rst_n;
    assign pending   = h_q.req_tgl != h_q.ack_s2;
    assign cmd_full  = {f_q.cmd[6:0], io_i[0]};
    assign addr_full = {f_q.addr[27:0], io_i};
    assign win_full  = {f_q.sh[27:0], io_i};

    always_comb begin
        f_d        = f_q;
        h_d        = h_q;
        h_d.ack_s1 = ack_tgl_i;
        h_d.ack_s2 = h_q.ack_s1;
        check_edge = 1'b0;
        iss        = 1'b0;
        iss_wr     = 1'b0;
        iss_addr   = '0;
        iss_data   = '0;

        case (f_q.phase)
            PH_CMD: begin
                f_d.cmd = cmd_full;
                f_d.cnt = f_q.cnt + 1'b1;
                if (f_q.cnt == LAST_NIB) begin
                    f_d.cnt = '0;
                    if (cmd_full == OP_QREAD) begin
                        f_d.phase   = PH_ADDR;
                        f_d.is_read = 1'b1;
                    end else if (cmd_full == OP_QWRITE) begin
                        f_d.phase   = PH_ADDR;
                        f_d.is_read = 1'b0;
                    end else begin
                        f_d.phase = PH_SKIP;
                    end
                end
            end
            PH_ADDR: begin
                f_d.addr = addr_full;
                f_d.cnt  = f_q.cnt + 1'b1;
                if (f_q.cnt == LAST_NIB) begin
                    f_d.cnt = '0;
                    if (f_q.is_read) begin
                        f_d.phase     = PH_DUMMY;
                        f_d.issued    = BURST_W'(1);
                        f_d.next_addr = addr_full + 32'd4;
                        f_d.have_req  = !pending;
                        iss           = !pending;
                        iss_addr      = addr_full;
                    end else begin
                        f_d.phase     = PH_WDATA;
                        f_d.next_addr = addr_full;
                    end
                end
            end
            PH_DUMMY: begin
                f_d.cnt = f_q.cnt + 1'b1;
                if (f_q.cnt == LAST_DUMMY) begin
                    f_d.cnt    = '0;
                    f_d.phase  = PH_RDATA;
                    check_edge = 1'b1;
                end
            end
            PH_RDATA: begin
                f_d.sh  = {f_q.sh[27:0], 4'h0};
                f_d.cnt = f_q.cnt + 1'b1;
                if (f_q.cnt == LAST_NIB) begin
                    f_d.cnt    = '0;
                    check_edge = 1'b1;
                end
            end
            PH_WDATA: begin
                f_d.sh  = win_full;
                f_d.cnt = f_q.cnt + 1'b1;
                if (f_q.cnt == LAST_NIB) begin
                    f_d.cnt       = '0;
                    f_d.next_addr = f_q.next_addr + 32'd4;
                    if (pending) begin
                        h_d.timeout = 1'b1;
                    end else begin
                        iss      = 1'b1;
                        iss_wr   = 1'b1;
                        iss_addr = f_q.next_addr;
                        iss_data = win_full;
                    end
                end
            end
            default: f_d = f_q;
        endcase

        if (check_edge) begin
            if (f_q.loaded < BURST_LIM) begin
                f_d.loaded = f_q.loaded + 1'b1;
                if (f_q.have_req && !pending) begin
                    f_d.sh = rsp_data_i;
                end else begin
                    f_d.sh      = FILL_WORD;
                    h_d.timeout = 1'b1;
                end
            end else begin
                f_d.sh = FILL_WORD;
            end
            f_d.have_req = 1'b0;
            if (f_q.issued < BURST_LIM) begin
                f_d.issued    = f_q.issued + 1'b1;
                f_d.next_addr = f_q.next_addr + 32'd4;
                if (!pending) begin
                    f_d.have_req = 1'b1;
                    iss          = 1'b1;
                    iss_addr     = f_q.next_addr;
                end
            end
        end

        if (iss) begin
            h_d.req_tgl   = ~h_q.req_tgl;
            h_d.req_write = iss_wr;
            h_d.req_addr  = iss_addr;
            if (iss_wr) begin
                h_d.req_wdata = iss_data;
            end
        end
    end

    always_ff @(posedge sck or posedge frame_rst) begin
        if (frame_rst) f_q <= '0;
        else           f_q <= f_d;
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign io_o        = f_q.sh[31:28];
    assign io_oe       = (f_q.phase == PH_RDATA) ? 4'hF : 4'h0;
    assign req_tgl_o   = h_q.req_tgl;
    assign req_write_o = h_q.req_write;
    assign req_addr_o  = h_q.req_addr;
    assign req_wdata_o = h_q.req_wdata;
    assign timeout_o   = h_q.timeout;
endmodule

// File: rtl/qsab_apb_master.sv
`timescale 1ns/1ps
module qsab_apb_master
    import qsab_pkg::*;
(
    input  logic        pclk,
    input  logic        presetn,
    input  logic        req_tgl_i,
    input  logic        req_write_i,
    input  logic [31:0] req_addr_i,
    input  logic [31:0] req_wdata_i,
    output logic        ack_tgl_o,
    output logic [31:0] rsp_data_o,
    input  logic        timeout_spi_i,
    output logic        timeout_o,
    output logic        slverr_o,
    output logic        psel,
    output logic        penable,
    output logic        pwrite,
    output logic [31:0] paddr,
    output logic [31:0] pwdata,
    input  logic [31:0] prdata,
    input  logic        pready,
    input  logic        pslverr
);
    typedef struct packed {
        apb_phase_e  st;
        logic        req_s1;
        logic        req_s2;
        logic        seen;
        logic        ack;
        logic        psel;
        logic        penable;
        logic        pwrite;
        logic [31:0] paddr;
        logic [31:0] pwdata;
        logic [31:0] rsp;
        logic        slverr;
        logic        to_s1;
        logic        to_s2;
    } apb_t;

    apb_t a_d, a_q;

    always_comb begin
        a_d        = a_q;
        a_d.req_s1 = req_tgl_i;
        a_d.req_s2 = a_q.req_s1;
        a_d.to_s1  = timeout_spi_i;
        a_d.to_s2  = a_q.to_s1;
        case (a_q.st)
            AP_IDLE: begin
                if (a_q.req_s2 != a_q.seen) begin
                    a_d.seen    = a_q.req_s2;
                    a_d.psel    = 1'b1;
                    a_d.penable = 1'b0;
                    a_d.pwrite  = req_write_i;
                    a_d.paddr   = req_addr_i;
                    a_d.pwdata  = req_wdata_i;
                    a_d.st      = AP_SETUP;
                end
            end
            AP_SETUP: begin
                a_d.penable = 1'b1;
                a_d.st      = AP_ACCESS;
            end
            AP_ACCESS: begin
                if (pready) begin
                    a_d.psel    = 1'b0;
                    a_d.penable = 1'b0;
                    a_d.st      = AP_IDLE;
                    a_d.ack     = ~a_q.ack;
                    if (!a_q.pwrite) begin
                        a_d.rsp = pslverr ? FILL_WORD : prdata;
                    end
                    if (pslverr) begin
                        a_d.slverr = 1'b1;
                    end
                end
            end
            default: a_d.st = AP_IDLE;
        endcase
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) a_q <= '0;
        else          a_q <= a_d;
    end

    assign ack_tgl_o  = a_q.ack;
    assign rsp_data_o = a_q.rsp;
    assign timeout_o  = a_q.to_s2;
    assign slverr_o   = a_q.slverr;
    assign psel       = a_q.psel;
    assign penable    = a_q.penable;
    assign pwrite     = a_q.pwrite;
    assign paddr      = a_q.paddr;
    assign pwdata     = a_q.pwdata;
endmodule

// File: rtl/qspi_apb_bridge.sv
`timescale 1ns/1ps
module qspi_apb_bridge #(
    parameter int DUMMY_CYCLES    = 8,
    parameter int MAX_BURST_WORDS = 8
) (
    input  logic        pclk,
    input  logic        presetn,
    input  logic        sck,
    input  logic        cs_n,
    input  logic [3:0]  io_i,
    output logic [3:0]  io_o,
    output logic [3:0]  io_oe,
    output logic        psel,
    output logic        penable,
    output logic        pwrite,
    output logic [31:0] paddr,
    output logic [31:0] pwdata,
    input  logic [31:0] prdata,
    input  logic        pready,
    input  logic        pslverr,
    output logic        timeout_o,
    output logic        slverr_o
);
    logic        req_tgl;
    logic        req_write;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic        ack_tgl;
    logic [31:0] rsp_data;
    logic        timeout_spi;

    qsab_link #(
        .DUMMY_CYCLES   (DUMMY_CYCLES),
        .MAX_BURST_WORDS(MAX_BURST_WORDS)
    ) u_link (
        .sck        (sck),
        .cs_n       (cs_n),
        .rst_n      (presetn),
        .io_i       (io_i),
        .io_o       (io_o),
        .io_oe      (io_oe),
        .req_tgl_o  (req_tgl),
        .req_write_o(req_write),
        .req_addr_o (req_addr),
        .req_wdata_o(req_wdata),
        .ack_tgl_i  (ack_tgl),
        .rsp_data_i (rsp_data),
        .timeout_o  (timeout_spi)
    );

    qsab_apb_master u_apb (
        .pclk         (pclk),
        .presetn      (presetn),
        .req_tgl_i    (req_tgl),
        .req_write_i  (req_write),
        .req_addr_i   (req_addr),
        .req_wdata_i  (req_wdata),
        .ack_tgl_o    (ack_tgl),
        .rsp_data_o   (rsp_data),
        .timeout_spi_i(timeout_spi),
        .timeout_o    (timeout_o),
        .slverr_o     (slverr_o),
        .psel         (psel),
        .penable      (penable),
        .pwrite       (pwrite),
        .paddr        (paddr),
        .pwdata       (pwdata),
        .prdata       (prdata),
        .pready       (pready),
        .pslverr      (pslverr)
    );
endmodule

// File: rtl/qsab_checker.sv
`timescale 1ns/1ps
module qsab_checker (
    input logic        pclk,
    input logic        presetn,
    input logic        cs_n,
    input logic [3:0]  io_oe,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [31:0] paddr,
    input logic [31:0] pwdata,
    input logic        pready,
    input logic        timeout_o,
    input logic        slverr_o
);
    AST_ENABLE_NEEDS_SELECT: assert property (@(posedge pclk) disable iff (!presetn)
        penable |-> psel); // R4
    AST_SETUP_BEFORE_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(penable) |-> $past(psel)); // R4
    AST_WAIT_HOLDS_BUS: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pready) |=> (psel && penable && $stable(paddr)
                                          && $stable(pwrite) && $stable(pwdata))); // R4
    AST_DONE_RELEASES: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pready) |=> !penable); // R4
    AST_OE_ALL_OR_NONE: assert property (@(posedge pclk) disable iff (!presetn)
        (io_oe == 4'h0) || (io_oe == 4'hF)); // R9
    AST_DESELECT_TRISTATES: assert property (@(posedge pclk) disable iff (!presetn)
        cs_n |-> (io_oe == 4'h0)); // R9
    AST_TIMEOUT_STICKY: assert property (@(posedge pclk) disable iff (!presetn)
        timeout_o |=> timeout_o); // R6
    AST_SLVERR_STICKY: assert property (@(posedge pclk) disable iff (!presetn)
        slverr_o |=> slverr_o); // R7
endmodule

bind qspi_apb_bridge qsab_checker u_qsab_checker (
    .pclk     (pclk),
    .presetn  (presetn),
    .cs_n     (cs_n),
    .io_oe    (io_oe),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .pready   (pready),
    .timeout_o(timeout_o),
    .slverr_o (slverr_o)
);

// File: tb/qspi_apb_bridge_bench.sv
`timescale 1ns/1ps
module qspi_apb_bridge_bench;
    localparam int          DUMMY    = 8;
    localparam int          HALF     = 20;
    localparam logic [31:0] FILL     = 32'hDEADBEEF;
    localparam logic [31:0] ERR_ADDR = 32'h0000_00F0;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic [3:0]  io_i = 4'h0;
    logic [3:0]  io_o, io_oe;
    logic        psel, penable, pwrite;
    logic [31:0] paddr, pwdata;
    logic [31:0] prdata = '0;
    logic        pready = 1'b0;
    logic        pslverr = 1'b0;
    logic        timeout_o, slverr_o;

    always #2.5 pclk = ~pclk;

    qspi_apb_bridge #(.DUMMY_CYCLES(DUMMY), .MAX_BURST_WORDS(8)) u_qspi_apb_bridge (
        .pclk(pclk), .presetn(presetn), .sck(sck), .cs_n(cs_n),
        .io_i(io_i), .io_o(io_o), .io_oe(io_oe),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .timeout_o(timeout_o), .slverr_o(slverr_o)
    );

    typedef struct {
        string       req;
        logic [63:0] val;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];

    int checks = 0;
    int failures = 0;
    int wait_n = 0;
    int wcnt_s = 0;
    int rd_count = 0;
    int wr_count = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] mem [64];
    bit oe_seen_idle = 1'b0;
    bit oe_miss_data = 1'b0;

    function automatic logic [31:0] init_word(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {8'hC0 ^ b, 8'h5A, b, ~b};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_item(input string req, input logic [63:0] val);
        item_t it;
        it.req = req;
        it.val = val;
        exp_q.push_back(it);
    endtask

    // APB slave model: responds at falling pclk edges
    always @(negedge pclk) begin
        if (psel && penable && !pready) begin
            if (wcnt_s >= wait_n) begin
                pready = 1'b1;
                if (pwrite) begin
                    item_t it;
                    mem[paddr[7:2]] = pwdata;
                    wr_count++;
                    it.req = "R8";
                    it.val = {paddr, pwdata};
                    act_q.push_back(it);
                end else begin
                    rd_count++;
                    last_rd_addr = paddr;
                    prdata  = mem[paddr[7:2]];
                    pslverr = (paddr == ERR_ADDR);
                end
            end else begin
                wcnt_s++;
            end
        end else begin
            pready  = 1'b0;
            pslverr = 1'b0;
            wcnt_s  = 0;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge pclk);
            while (act_q.size() > 0) begin
                item_t a, e;
                a = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, a.req, a.val, 64'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(a.val === e.val, e.req, a.val, e.val);
                end
            end
        end
    end

    task automatic sck_cycle(input logic [3:0] d);
        io_i = d;
        #HALF;
        if (io_oe != 4'h0) oe_seen_idle = 1'b1;
        sck = 1'b1;
        #HALF;
        sck = 1'b0;
    endtask

    task automatic send_head(input logic [7:0] op, input logic [31:0] a);
        cs_n = 1'b0;
        #HALF;
        for (int i = 7; i >= 0; i--) sck_cycle({3'b000, op[i]});
        for (int i = 7; i >= 0; i--) sck_cycle(a[i*4 +: 4]);
    endtask

    task automatic end_frame;
        io_i = 4'h0;
        #HALF;
        cs_n = 1'b1;
        #(10 * HALF);
    endtask

    task automatic spi_read(input logic [31:0] a, input int nwords);
        send_head(8'h6B, a);
        for (int i = 0; i < DUMMY; i++) sck_cycle(4'h0);
        for (int w = 0; w < nwords; w++) begin
            logic [31:0] word;
            item_t it;
            word = '0;
            for (int n = 0; n < 8; n++) begin
                #HALF;
                if (io_oe != 4'hF) oe_miss_data = 1'b1;
                word = {word[27:0], io_o};
                sck = 1'b1;
                #HALF;
                sck = 1'b0;
            end
            it.req = "R3";
            it.val = {32'h0, word};
            act_q.push_back(it);
        end
        end_frame();
    endtask

    task automatic spi_write(input logic [31:0] a, input logic [31:0] d0,
                             input logic [31:0] d1, input int nwords, input int extra);
        send_head(8'h32, a);
        for (int w = 0; w < nwords; w++) begin
            logic [31:0] d;
            d = (w == 0) ? d0 : d1;
            for (int n = 7; n >= 0; n--) sck_cycle(d[n*4 +: 4]);
        end
        for (int n = 0; n < extra; n++) sck_cycle(4'hA);
        end_frame();
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        for (int i = 0; i < 64; i++) mem[i] = init_word(i);
        repeat (10) @(posedge pclk);
        #1;
        // R1: reset values
        check(psel == 1'b0 && penable == 1'b0, "R1", {psel, penable}, 0);
        check(io_oe == 4'h0, "R1", io_oe, 0);
        check(timeout_o == 1'b0 && slverr_o == 1'b0, "R1", {timeout_o, slverr_o}, 0);
        presetn = 1'b1;
        repeat (5) @(posedge pclk);

        // R3: single read, fast slave
        wait_n = 0;
        expect_item("R3", {32'h0, init_word(4)});
        spi_read(32'h10, 1);
        check(oe_seen_idle == 1'b0, "R9", oe_seen_idle, 0);
        check(oe_miss_data == 1'b0, "R9", oe_miss_data, 0);

        // R5: three-word burst with wait states
        wait_n = 2;
        for (int i = 0; i < 3; i++) expect_item("R5", {32'h0, init_word(8 + i)});
        spi_read(32'h20, 3);
        #1000;

        // R5: burst beyond limit
        wait_n = 1;
        base = rd_count;
        for (int i = 0; i < 8; i++) expect_item("R5", {32'h0, init_word(16 + i)});
        expect_item("R5", {32'h0, FILL});
        expect_item("R5", {32'h0, FILL});
        spi_read(32'h40, 10);
        #1000;
        check(rd_count - base == 8, "R5", rd_count - base, 8);
        check(last_rd_addr == 32'h5C, "R5", last_rd_addr, 32'h5C);
        check(timeout_o == 1'b0, "R5", timeout_o, 0);

        // R7: slave error
        wait_n = 0;
        expect_item("R7", {32'h0, FILL});
        spi_read(ERR_ADDR, 1);
        #500;
        check(slverr_o == 1'b1, "R7", slverr_o, 1);
        check(timeout_o == 1'b0, "R7", timeout_o, 0);

        // R2: unknown opcode is ignored
        base = rd_count + wr_count;
        oe_seen_idle = 1'b0;
        send_head(8'h03, 32'h10);
        for (int i = 0; i < 24; i++) sck_cycle(4'h5);
        end_frame();
        #500;
        check(rd_count + wr_count == base, "R2", rd_count + wr_count, base);
        check(oe_seen_idle == 1'b0, "R2", oe_seen_idle, 0);

        // R8: single write
        expect_item("R8", {32'h80, 32'h1234_5678});
        spi_write(32'h80, 32'h1234_5678, 32'h0, 1, 0);
        #500;

        // R8: two words plus a fragment
        base = wr_count;
        expect_item("R8", {32'h90, 32'hCAFE_F00D});
        expect_item("R8", {32'h94, 32'h0BAD_1DEA});
        spi_write(32'h90, 32'hCAFE_F00D, 32'h0BAD_1DEA, 2, 3);
        #500;
        check(wr_count - base == 2, "R8", wr_count - base, 2);
        expect_item("R8", {32'h0, 32'hCAFE_F00D});
        spi_read(32'h90, 1);
        check(oe_seen_idle == 1'b0, "R9", oe_seen_idle, 0);

        // R6: stalled slave misses the window
        wait_n = 300;
        expect_item("R6", {32'h0, FILL});
        spi_read(32'h08, 1);
        #3000;
        check(timeout_o == 1'b1, "R6", timeout_o, 1);
        wait_n = 0;
        expect_item("R6", {32'h0, init_word(3)});
        spi_read(32'h0C, 1);
        #500;
        check(timeout_o == 1'b1, "R6", timeout_o, 1);
        check(oe_miss_data == 1'b0, "R9", oe_miss_data, 0);

        repeat (50) @(posedge pclk);
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule